// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block buffers characters arriving from a serial receiver until the host collects them. Each entry keeps the received byte together with three error flags for that character: parity error, framing error and break. The flags travel through the queue with their byte, so the host sees them only when that character reaches the head. Errors therefore always line up with the data they belong to.

The host side has a data-read strobe and a line-status read strobe. A packed line-status byte reports data-ready, a sticky overrun flag and the head character's error flags. A level-triggered receive interrupt fires when the fill count reaches a programmable threshold. The fill count is also exported so a flow-control block can pace the remote transmitter.

A mode input switches between full queue operation and a single-character holding register. A clear input empties the queue in one cycle.

A small state machine tracks occupancy in three states. **FS_EMPTY** means no entries. **FS_PARTIAL** means some entries but below capacity. **FS_FULL** means capacity is reached. The transitions are:

- **accept**: FS_EMPTY to FS_PARTIAL, or FS_EMPTY/FS_PARTIAL to FS_FULL.
- **drain**: FS_PARTIAL/FS_FULL to FS_EMPTY, or FS_FULL to FS_PARTIAL.
- **hold**: the state does not change.
- **flush**: any state to FS_EMPTY when cleared.

The next state is taken from the next fill count.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the fill count is 0, the line-status byte is 0x00, the interrupt is low and the read data is 0.
- R2: With `fifo_en`=1, up to DEPTH characters are stored and read back in arrival order. `fill_cnt` changes in the cycle after each accepted write or read.
- R3: With `fifo_en`=0, the block holds at most one character. A second write before it is read is dropped and raises overrun. Mode changes are made together with `fifo_clr`=1.
- R4: A write arriving while the queue is full is dropped. Stored contents and the fill count stay unchanged, and overrun (line-status bit 1) is set.
- R5: Overrun stays set until a cycle with `lsr_rd`=1 clears it. If a new overrun occurs in that same cycle, the flag stays set.
- R6: Line-status bit 0 (data ready) is 1 exactly when the fill count is non-zero.
- R7: Line-status bits 2, 3 and 4 show the parity, framing and break flags of the head character. Those flags are `wr_tag` bits 0, 1 and 2 at write time. Line-status bits 7:5 are always 0. When the queue is empty, bits 4:2 and `rd_data` are 0.
- R8: With `fifo_en`=1, `rx_trig_irq` is high exactly when the fill count is at least `trig_lvl`, with a level of 0 treated as 1. It drops in the cycle the count falls below that level. With `fifo_en`=0, the interrupt equals data ready.
- R9: `fifo_clr` empties the queue and clears overrun by the next cycle. It overrides a write or read in the same cycle.
- R10: A read strobe while empty has no effect. The fill count stays 0 and the line-status byte is unchanged.
- R11: A read and a write in the same cycle, while not full, leave the fill count unchanged and keep the order. When full, the full check uses the count before the read, so the write is dropped with overrun while the read still removes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of entries and overrun |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding register |
| trig_lvl | input | CNTW | Interrupt threshold (CNTW = 7 at default DEPTH) |
| wr_valid | input | 1 | A received character is presented |
| wr_data | input | DATA_W | Received byte |
| wr_tag | input | 3 | bit0 parity error, bit1 framing error, bit2 break |
| rd_strobe | input | 1 | Host takes the head character |
| lsr_rd | input | 1 | Host reads line status (clears overrun) |
| rd_data | output | DATA_W | Head character, 0 when empty |
| line_stat | output | 8 | bit0 ready, bit1 overrun, bits 4:2 head flags |
| rx_trig_irq | output | 1 | Receive threshold interrupt |
| fill_cnt | output | CNTW | Number of stored characters |

## Verification
The bench builds the block with DEPTH=8, which gives CNTW=4. That depth makes full, overrun-on-full and wrap-around of the pointers reachable in a handful of cycles. Every threshold from 0 to 8 is swept across a full fill and a full drain, so each fill count meets each threshold. Holding mode, clear-with-traffic and simultaneous read/write at mid-fill and at full are also driven. All outputs are compared each cycle against an arithmetic queue model.

// File: rtl/rx_tag_pkg.sv
package rx_tag_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

    localparam int TAG_W    = 3;
    localparam int LS_READY = 0;
    localparam int LS_OVR   = 1;
    localparam int LS_TAG_LO = 2;

endpackage

// File: rtl/rx_tag_mem.sv
module rx_tag_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 11,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rx_tag_ctrl.sv
module rx_tag_ctrl
    import rx_tag_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            fifo_en,
    input  logic            wr_valid,
    input  logic            rd_req,
    output logic            push,
    output logic            ovr_evt,
    output logic [AW-1:0]   wptr,
    output logic [AW-1:0]   rptr,
    output logic [CNTW-1:0] cnt
);

    fill_state_e     st, st_nxt;
    logic            is_empty, is_full, pop;
    logic [CNTW-1:0] cap, cnt_nxt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= FS_EMPTY;
        end else begin
            st <= st_nxt;
        end
    end

    // outputs decoded from the state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (st)
            FS_EMPTY:   is_empty = 1'b1;
            FS_PARTIAL: ;
            FS_FULL:    is_full  = 1'b1;
            default:    is_empty = 1'b1;
        endcase
    end

    always_comb begin
        cap     = fifo_en ? CNTW'(DEPTH) : CNTW'(1);
        pop     = rd_req && !is_empty && !clr;
        push    = wr_valid && !is_full && !clr;
        ovr_evt = wr_valid && is_full && !clr;
        cnt_nxt = clr ? '0 : cnt + CNTW'(push) - CNTW'(pop);
    end

    // next state: accept / drain / hold / flush
    always_comb begin
        if (cnt_nxt == '0) begin
            st_nxt = FS_EMPTY;
        end else if (cnt_nxt >= cap) begin
            st_nxt = FS_FULL;
        end else begin
            st_nxt = FS_PARTIAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            cnt  <= '0;
            wptr <= '0;
            rptr <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
        end
    end

endmodule

// File: rtl/rx_tag_status.sv
module rx_tag_status
    import rx_tag_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lsr_rd,
    input  logic             ovr_evt,
    input  logic             fifo_en,
    input  logic [CNTW-1:0]  trig_lvl,
    input  logic [CNTW-1:0]  cnt,
    input  logic [TAG_W-1:0] head_tag,
    output logic [7:0]       line_stat,
    output logic             irq
);

    logic            ovr_q;
    logic            has_data;
    logic [CNTW-1:0] trig_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (clr) begin
            ovr_q <= 1'b0;
        end else if (ovr_evt) begin
            ovr_q <= 1'b1;
        end else if (lsr_rd) begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        has_data = (cnt != '0);
        trig_eff = (trig_lvl == '0) ? CNTW'(1) : trig_lvl;
        irq      = fifo_en ? (cnt >= trig_eff) : has_data;
        line_stat = '0;
        line_stat[LS_READY] = has_data;
        line_stat[LS_OVR]   = ovr_q;
        line_stat[LS_TAG_LO +: TAG_W] = has_data ? head_tag : '0;
    end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rx_tag_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              fifo_en,
    input  logic [CNTW-1:0]   trig_lvl,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        wr_tag,
    input  logic              rd_strobe,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        line_stat,
    output logic              rx_trig_irq,
    output logic [CNTW-1:0]   fill_cnt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EW = DATA_W + TAG_W;

    logic          push, ovr_evt;
    logic [AW-1:0] wptr, rptr;
    logic [EW-1:0] head;

    rx_tag_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .fifo_en(fifo_en),
        .wr_valid(wr_valid), .rd_req(rd_strobe), .push(push),
        .ovr_evt(ovr_evt), .wptr(wptr), .rptr(rptr), .cnt(fill_cnt)
    );

    rx_tag_mem #(.DEPTH(DEPTH), .W(EW)) u_mem (
        .clk(clk), .we(push), .waddr(wptr), .wdata({wr_tag, wr_data}),
        .raddr(rptr), .rdata(head)
    );

    rx_tag_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .lsr_rd(lsr_rd),
        .ovr_evt(ovr_evt), .fifo_en(fifo_en), .trig_lvl(trig_lvl),
        .cnt(fill_cnt), .head_tag(head[EW-1 -: TAG_W]),
        .line_stat(line_stat), .irq(rx_trig_irq)
    );

    assign rd_data = (fill_cnt != '0) ? head[DATA_W-1:0] : '0;

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_clr,
    input logic              fifo_en,
    input logic [CNTW-1:0]   trig_lvl,
    input logic              wr_valid,
    input logic              rd_strobe,
    input logic              lsr_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic [7:0]        line_stat,
    input logic              rx_trig_irq,
    input logic [CNTW-1:0]   fill_cnt
);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNTW'(DEPTH));

    a_r3_holding_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && fill_cnt == CNTW'(1) && wr_valid && !rd_strobe && !fifo_clr)
        |=> (fill_cnt == CNTW'(1) && line_stat[1]));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && fill_cnt == CNTW'(DEPTH) && wr_valid && !rd_strobe && !fifo_clr)
        |=> (fill_cnt == CNTW'(DEPTH) && line_stat[1]));

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stat[1] && !lsr_rd && !fifo_clr) |=> line_stat[1]);

    a_r6_ready: assert property (@(posedge clk) disable iff (!rst_n)
        line_stat[0] == (fill_cnt != '0));

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) |-> (line_stat[4:2] == 3'b000 && rd_data == '0));

    a_r8_irq_below: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && trig_lvl != '0 && fill_cnt < trig_lvl) |-> !rx_trig_irq);

    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fill_cnt == '0 && line_stat[1:0] == 2'b00 && !rx_trig_irq));

    a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0 && rd_strobe && !wr_valid && !fifo_clr) |=> fill_cnt == '0);

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
    .trig_lvl(trig_lvl), .wr_valid(wr_valid), .rd_strobe(rd_strobe),
    .lsr_rd(lsr_rd), .rd_data(rd_data), .line_stat(line_stat),
    .rx_trig_irq(rx_trig_irq), .fill_cnt(fill_cnt)
);

// File: tb/rx_tag_fifo_tb.sv
module rx_tag_fifo_tb_top;

    localparam int DEPTH = 8;
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fifo_clr = 1'b0, fifo_en = 1'b1;
    logic [CNTW-1:0] trig_lvl = CNTW'(3);
    logic            wr_valid = 1'b0, rd_strobe = 1'b0, lsr_rd = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [2:0]      wr_tag = '0;
    logic [7:0]      rd_data, line_stat;
    logic            rx_trig_irq;
    logic [CNTW-1:0] fill_cnt;

    int total = 0;
    int bad   = 0;

    logic [10:0] q[$];
    bit          m_ovr = 1'b0;

    always #5 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
        .trig_lvl(trig_lvl), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_tag(wr_tag), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
        .rd_data(rd_data), .line_stat(line_stat), .rx_trig_irq(rx_trig_irq),
        .fill_cnt(fill_cnt)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk(input string req);
        int sz = q.size();
        int te = (trig_lvl == 0) ? 1 : int'(trig_lvl);
        logic [7:0] ls;
        logic exp_irq;
        ls = 8'h00;
        ls[0] = (sz != 0);
        ls[1] = m_ovr;
        if (sz != 0) ls[4:2] = q[0][10:8];
        exp_irq = fifo_en ? (sz >= te) : (sz != 0);
        cmp(req, "fill_cnt", int'(fill_cnt), sz);
        cmp(req, "line_stat", int'(line_stat), int'(ls));
        cmp(req, "irq", int'(rx_trig_irq), int'(exp_irq));
        cmp(req, "rd_data", int'(rd_data), (sz != 0) ? int'(q[0][7:0]) : 0);
    endtask

    task automatic cyc(input bit wv, input logic [7:0] d, input logic [2:0] t,
                       input bit rd, input bit lrd, input bit clr, input string req);
        int  cap;
        bit  full;
        wr_valid = wv; wr_data = d; wr_tag = t;
        rd_strobe = rd; lsr_rd = lrd; fifo_clr = clr;
        @(posedge clk);
        if (clr) begin
            q.delete();
            m_ovr = 1'b0;
        end else begin
            cap  = fifo_en ? DEPTH : 1;
            full = (q.size() >= cap);
            if (wv && full) m_ovr = 1'b1;
            else if (lrd)   m_ovr = 1'b0;
            if (rd && q.size() > 0) void'(q.pop_front());
            if (wv && !full) q.push_back({t, d});
        end
        @(negedge clk);
        wr_valid = 1'b0; rd_strobe = 1'b0; lsr_rd = 1'b0; fifo_clr = 1'b0;
        chk(req);
    endtask

    task automatic drain(input string req);
        while (q.size() > 0) cyc(0, 8'h00, 3'b000, 1, 0, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1");

        // R2 / R7 / R8: fill with varying flags
        for (int i = 0; i < DEPTH; i++)
            cyc(1, 8'(8'hA0 + i * 7), 3'(i), 0, 0, 0, "R2");
        // R4: write on full
        cyc(1, 8'hEE, 3'b111, 0, 0, 0, "R4");
        cyc(1, 8'hEF, 3'b111, 0, 0, 0, "R4");
        // R11: read + write at full -> write dropped
        cyc(1, 8'hE1, 3'b001, 1, 0, 0, "R11");
        cyc(1, 8'h55, 3'b010, 0, 0, 0, "R2");
        // R5: overrun again in same cycle as lsr read keeps flag
        cyc(1, 8'h66, 3'b000, 0, 1, 0, "R5");
        cyc(0, 8'h00, 3'b000, 0, 0, 0, "R5");
        cyc(0, 8'h00, 3'b000, 0, 1, 0, "R5");
        drain("R2");
        // R10: read on empty
        cyc(0, 8'h00, 3'b000, 1, 0, 0, "R10");
        cyc(0, 8'h00, 3'b000, 1, 1, 0, "R10");
        // R11: mid-level simultaneous read/write, wraps pointers
        for (int i = 0; i < 3; i++) cyc(1, 8'(8'h10 + i), 3'(i + 4), 0, 0, 0, "R11");
        for (int i = 0; i < 10; i++) cyc(1, 8'(8'h30 + i), 3'(i), 1, 0, 0, "R11");
        drain("R6");
        // R8: threshold sweep
        for (int tr = 0; tr <= DEPTH; tr++) begin
            trig_lvl = CNTW'(tr);
            cyc(0, 8'h00, 3'b000, 0, 0, 1, "R9");
            for (int i = 0; i < DEPTH; i++) cyc(1, 8'(tr * 16 + i), 3'(tr + i), 0, 0, 0, "R8");
            drain("R8");
        end
        // R9: clear with overrun pending and traffic in the same cycle
        trig_lvl = CNTW'(3);
        for (int i = 0; i < DEPTH + 1; i++) cyc(1, 8'(i), 3'b100, 0, 0, 0, "R4");
        cyc(1, 8'h77, 3'b001, 1, 0, 1, "R9");
        cyc(0, 8'h00, 3'b000, 0, 0, 0, "R9");
        // R3: holding mode
        fifo_en = 1'b0;
        cyc(0, 8'h00, 3'b000, 0, 0, 1, "R3");
        cyc(1, 8'h5A, 3'b011, 0, 0, 0, "R3");
        cyc(1, 8'h5B, 3'b100, 0, 0, 0, "R3");
        cyc(1, 8'h5C, 3'b100, 1, 0, 0, "R3");
        cyc(1, 8'h5D, 3'b110, 0, 1, 0, "R3");
        cyc(0, 8'h00, 3'b000, 1, 1, 0, "R3");
        cyc(1, 8'h5E, 3'b010, 0, 0, 0, "R3");
        cyc(0, 8'h00, 3'b000, 1, 0, 0, "R3");
        fifo_en = 1'b1;
        cyc(0, 8'h00, 3'b000, 0, 0, 1, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule